// File: doc/BRIEF.md
# Horizontal Four-Way Branch Microsequencer

This block is the control unit of a small processor built in the horizontal microprogrammed style. A constant control store holds one 40-bit word per state. Each word carries every datapath control point as its own bit, with no encoding, so the datapath is driven straight from the store. The same word also holds four complete next-state addresses and the select bits of two condition multiplexers.

In each state, the first multiplexer chooses between the memory wait flag and instruction bit 15. The second chooses between the accumulator sign bit and instruction bit 14. The two chosen bits form a 2-bit index that picks one of the four stored addresses, and that address is loaded into the 4-bit state register on the next rising clock edge. The block is a Moore machine: the control outputs depend only on the current state.

The store contents are a parameter, so an integrator supplies the microprogram at elaboration time. The datapath and the memory are outside the block.

Top module: `horiz_useq`

## Requirements
- R1: A control word is 40 bits wide, laid out as follows: bit 39 is the first-mux select, bit 38 is the second-mux select, bits 37:34 hold next-state field A0, bits 33:30 hold A1, bits 29:26 hold A2, bits 25:22 hold A3, and bits 21:0 are the microoperation bits. Word s occupies bits [s*40 +: 40] of the STORE parameter.
- R2: The first condition bit equals `mem_wait` when bit 39 is 0 and `ir_b15` when bit 39 is 1.
- R3: The second condition bit equals `acc_msb` when bit 38 is 0 and `ir_b14` when bit 38 is 1.
- R4: On each rising clock edge out of reset, the state register loads the next-state field chosen by the index {first, second}: 00 selects A0, 01 selects A1, 10 selects A2 and 11 selects A3. A status input whose multiplexer is not selecting it has no effect on the next state.
- R5: A state whose A0 and A1 fields hold its own number, whose A2 and A3 fields hold its successor, and whose first-mux select is 0 stays in place while `mem_wait` is low. It moves to the successor on the first edge at which `mem_wait` is high.
- R6: Reset is synchronous and active low. Any edge with `rst_n` low puts the state register at 0000, whatever the store and the status inputs hold, and the register stays there for as long as `rst_n` remains low.
- R7: `uop` equals bits 21:0 of the current state's word, bit for bit and without decoding, and it is driven combinationally from the state register.
- R8: `uop` changes only when the state changes. Toggling the status inputs within a cycle leaves `uop` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_wait | input | 1 | Memory handshake status, first-mux input 0 |
| ir_b15 | input | 1 | Instruction bit 15, first-mux input 1 |
| ir_b14 | input | 1 | Instruction bit 14, second-mux input 1 |
| acc_msb | input | 1 | Accumulator sign bit, second-mux input 0 |
| uop | output | 22 | Raw microoperation control bits of the current state |

## Verification
The assertions assume that the four status inputs are synchronous to `clk` and stable around the rising edge. They also assume that `rst_n` is low at the first edge, so that the state register starts from a known value. The bench meets both conditions by changing every input shortly after a rising edge and by starting with reset asserted. The bench's microprogram gives each state a distinct `uop` pattern, so the state the block has reached can be read at the ports alone. It exercises every index of both four-way branch states, and it drives the unselected status inputs to values that would change the outcome if they leaked through.

// File: rtl/ucode_pkg.sv
// Package: shared sizes and the default microprogram for the sequencer.
// Assumes the word layout {sel_a, sel_b, A0, A1, A2, A3, uops}, MSB first.
package ucode_pkg;

    localparam int STATE_W_D = 4;
    localparam int UOP_W_D   = 22;
    localparam int WAYS      = 4;
    localparam int DEPTH_D   = 1 << STATE_W_D;
    localparam int WORD_W_D  = 2 + WAYS * STATE_W_D + UOP_W_D;

    typedef logic [STATE_W_D-1:0] state_t;

    // Builds a default program: 0 -> 1, 1 waits for memory then goes to 2,
    // 2 returns to 0; every other state returns to 0. Each state asserts one uop bit.
    function automatic logic [DEPTH_D*WORD_W_D-1:0] default_store();
        logic [DEPTH_D*WORD_W_D-1:0] img;
        logic [WORD_W_D-1:0]         w;
        img = '0;
        for (int s = 0; s < DEPTH_D; s++) begin
            w = '0;
            w[UOP_W_D-1:0] = UOP_W_D'(1) << s;
            if (s == 0) begin
                w[WORD_W_D-3 -: WAYS*STATE_W_D] = {4{state_t'(1)}};
            end else if (s == 1) begin
                w[WORD_W_D-3 -: WAYS*STATE_W_D] = {state_t'(1), state_t'(1),
                                                   state_t'(2), state_t'(2)};
            end else begin
                w[WORD_W_D-3 -: WAYS*STATE_W_D] = '0;
            end
            img[s*WORD_W_D +: WORD_W_D] = w;
        end
        return img;
    endfunction

endpackage

// File: rtl/ucode_store.sv
// Module: constant control store. Unpacks a flat parameter image into words
// and returns the word at the given address combinationally.
// Assumes the image holds DEPTH words of WORD_W bits, word 0 in the LSBs.
module ucode_store #(
    parameter int STATE_W = 4,
    parameter int WORD_W  = 40,
    localparam int DEPTH  = 1 << STATE_W,
    parameter logic [DEPTH*WORD_W-1:0] IMAGE = '0
) (
    input  logic [STATE_W-1:0] addr,
    output logic [WORD_W-1:0]  word
);

    logic [WORD_W-1:0] rom [DEPTH];

    // One constant word per state, sliced out of the image.
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign rom[g] = IMAGE[g*WORD_W +: WORD_W];
    end

    // Read port: asynchronous look-up by state number.
    always_comb begin
        word = rom[addr];
    end

endmodule

// File: rtl/cond_mux.sv
// Module: one 2:1 condition multiplexer feeding the branch index.
// Assumes the status inputs are synchronous to the sequencer clock.
module cond_mux (
    input  logic sel,
    input  logic in0,
    input  logic in1,
    output logic pick
);

    // Pass the status bit that the control word names.
    always_comb begin
        pick = sel ? in1 : in0;
    end

endmodule

// File: rtl/next_sel.sv
// Module: four-way next-state selector. Picks one of WAYS stored addresses
// using the 2-bit condition index. Field 0 sits in the MSBs of the flat input.
module next_sel #(
    parameter int STATE_W = 4,
    parameter int WAYS    = 4,
    localparam int IDX_W  = $clog2(WAYS)
) (
    input  logic [WAYS*STATE_W-1:0] fields,
    input  logic [IDX_W-1:0]        idx,
    output logic [STATE_W-1:0]      next_state
);

    logic [STATE_W-1:0] cand [WAYS];

    // Unpack the candidate addresses, A0 first from the top.
    for (genvar k = 0; k < WAYS; k++) begin : g_field
        assign cand[k] = fields[(WAYS-1-k)*STATE_W +: STATE_W];
    end

    // Choose the candidate named by the condition index.
    always_comb begin
        next_state = cand[idx];
    end

endmodule

// File: rtl/horiz_useq.sv
// Module: horizontal microsequencer top. Holds the state register, reads the
// control word, steers two condition muxes and loads one of four next states.
// Assumes status inputs are stable around the rising edge and that rst_n is
// low at the first edge. Reset is synchronous, active low, to state 0.
module horiz_useq
    import ucode_pkg::*;
#(
    parameter int STATE_W = STATE_W_D,
    parameter int UOP_W   = UOP_W_D,
    localparam int NWAY   = 4,
    localparam int DEPTH  = 1 << STATE_W,
    localparam int WORD_W = 2 + NWAY * STATE_W + UOP_W,
    parameter logic [DEPTH*WORD_W-1:0] STORE = default_store()
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_wait,
    input  logic             ir_b15,
    input  logic             ir_b14,
    input  logic             acc_msb,
    output logic [UOP_W-1:0] uop
);

    logic [STATE_W-1:0]      state_q;
    logic [STATE_W-1:0]      next_state;
    logic [WORD_W-1:0]       word;
    logic                    sel_a;
    logic                    sel_b;
    logic                    cond_a;
    logic                    cond_b;
    logic [NWAY*STATE_W-1:0] fields;

    ucode_store #(
        .STATE_W (STATE_W),
        .WORD_W  (WORD_W),
        .IMAGE   (STORE)
    ) u_store (
        .addr (state_q),
        .word (word)
    );

    // Split the control word into its fixed fields.
    always_comb begin
        sel_a  = word[WORD_W-1];
        sel_b  = word[WORD_W-2];
        fields = word[WORD_W-3 -: NWAY*STATE_W];
        uop    = word[UOP_W-1:0];
    end

    cond_mux u_mux_a (
        .sel  (sel_a),
        .in0  (mem_wait),
        .in1  (ir_b15),
        .pick (cond_a)
    );

    cond_mux u_mux_b (
        .sel  (sel_b),
        .in0  (acc_msb),
        .in1  (ir_b14),
        .pick (cond_b)
    );

    next_sel #(
        .STATE_W (STATE_W),
        .WAYS    (NWAY)
    ) u_next (
        .fields     (fields),
        .idx        ({cond_a, cond_b}),
        .next_state (next_state)
    );

    // State register: direct synchronous clear, otherwise load the chosen address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= next_state;
        end
    end

    // R6: any edge with reset low leaves the register at zero.
    p_reset_zero_r6: assert property (@(posedge clk)
        !rst_n |=> state_q == '0);

    // R4: the register takes the address the selector offered.
    p_load_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> state_q == $past(next_state));

    // R2: first condition follows the named status input.
    p_mux_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a ? cond_a == ir_b15 : cond_a == mem_wait));

    // R3: second condition follows the named status input.
    p_mux_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b ? cond_b == ir_b14 : cond_b == acc_msb));

    // R5: a self-looping wait state holds while the memory is not ready.
    p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_a && !mem_wait && fields[NWAY*STATE_W-1 -: STATE_W] == state_q
         && fields[(NWAY-1)*STATE_W-1 -: STATE_W] == state_q)
        |=> $stable(state_q));

    // R8: outputs move only with the state (Moore behaviour).
    p_uop_moore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && $stable(state_q) |-> $stable(uop));

endmodule

// File: tb/sim_horiz_useq.sv
// Bench: supplies its own microprogram, walks a vector table of status inputs
// and expected states, then runs directed reset and Moore-output tests.
module sim_horiz_useq;

    localparam int SW = 4;
    localparam int UW = 22;
    localparam int WW = 40;
    localparam int ND = 16;

    // Distinct uop pattern per state: one-hot low bits plus the state number on top.
    function automatic logic [UW-1:0] pat(input int s);
        return (UW'(1) << s) | (UW'(s) << 16);
    endfunction

    // R1 layout: {sa, sb, A0, A1, A2, A3, uop}
    function automatic logic [WW-1:0] mk(input logic sa, input logic sb,
                                         input int a0, input int a1,
                                         input int a2, input int a3, input int s);
        return {sa, sb, 4'(a0), 4'(a1), 4'(a2), 4'(a3), pat(s)};
    endfunction

    function automatic logic [ND*WW-1:0] program_img();
        logic [ND*WW-1:0] img;
        for (int s = 0; s < ND; s++) begin
            case (s)
                0:       img[s*WW +: WW] = mk(0, 0, 1, 1, 1, 1, s);
                1:       img[s*WW +: WW] = mk(0, 0, 1, 1, 2, 2, s);
                2:       img[s*WW +: WW] = mk(1, 1, 3, 4, 5, 6, s);
                3:       img[s*WW +: WW] = mk(0, 0, 7, 8, 9, 10, s);
                default: img[s*WW +: WW] = mk(0, 1, 0, 0, 0, 0, s);
            endcase
        end
        return img;
    endfunction

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_wait = 1'b0;
    logic          ir_b15 = 1'b0;
    logic          ir_b14 = 1'b0;
    logic          acc_msb = 1'b0;
    logic [UW-1:0] uop;

    int n_chk = 0;
    int n_err = 0;

    horiz_useq #(.STORE(program_img())) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_wait (mem_wait),
        .ir_b15   (ir_b15),
        .ir_b14   (ir_b14),
        .acc_msb  (acc_msb),
        .uop      (uop)
    );

    always #10 clk = ~clk;

    // Vector: {wait, ir15, ir14, acc, expected state after the edge}
    localparam int NV = 30;
    localparam logic [7:0] VEC [NV] = '{
        8'b0000_0001,  // 0 -> 1
        8'b0000_0001,  // 1 holds, wait low (R5)
        8'b0101_0001,  // 1 holds, other inputs busy (R5)
        8'b1000_0010,  // 1 -> 2 on wait
        8'b1000_0011,  // 2: ir 00 -> A0, wait ignored (R4)
        8'b0000_0111,  // 3: wait0 acc0 -> 7 (R2, R3)
        8'b0000_0000,  // 7 -> 0
        8'b0000_0001,
        8'b1000_0010,
        8'b0010_0100,  // 2: ir 01 -> A1
        8'b0000_0000,
        8'b0000_0001,
        8'b1000_0010,
        8'b0101_0101,  // 2: ir 10 -> A2, acc ignored
        8'b0000_0000,
        8'b0000_0001,
        8'b1000_0010,
        8'b0110_0110,  // 2: ir 11 -> A3
        8'b0000_0000,
        8'b0000_0001,
        8'b1000_0010,
        8'b0000_0011,
        8'b0111_1000,  // 3: wait0 acc1 -> 8, ir ignored
        8'b0000_0000,
        8'b0000_0001,
        8'b1000_0010,
        8'b0000_0011,
        8'b1000_1001,  // 3: wait1 acc0 -> 9
        8'b0010_0000,  // 9 -> 0 (b-mux on ir14, all fields zero)
        8'b0000_0001
    };

    task automatic check(input string req, input logic [UW-1:0] act,
                         input logic [UW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: uop actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic drive(input logic [3:0] v);
        {mem_wait, ir_b15, ir_b14, acc_msb} = v;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R6: reset held for several edges, with busy inputs.
        drive(4'b1111);
        repeat (3) tick();
        check("R6 reset state", uop, pat(0));
        check("R7 uop from word 0", uop, 22'h000001);
        rst_n = 1'b1;
        drive(4'b0000);

        // Table walk: R2, R3, R4, R5, R7.
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][7:4]);
            tick();
            check("R4 vector", uop, pat(int'(VEC[i][3:0])));
        end

        // Back in state 1 now. R3 path: state 3 with wait1 acc1 -> 10.
        drive(4'b1000); tick();
        drive(4'b0000); tick();
        drive(4'b1001); tick();
        check("R3 state3 index 11", uop, pat(10));

        // R8: toggling inputs within a cycle leaves uop unchanged.
        drive(4'b0000); tick();
        check("R8 back to 0", uop, pat(0));
        drive(4'b0000); tick();
        for (int k = 0; k < 4; k++) begin
            drive(4'(k * 5));
            #3;
            check("R8 uop steady in state 1", uop, pat(1));
        end

        // R5: long wait, then release.
        drive(4'b0000);
        repeat (5) tick();
        check("R5 still waiting", uop, pat(1));
        drive(4'b1000); tick();
        check("R5 released", uop, pat(2));

        // R6: mid-run reset overrides the branch.
        rst_n = 1'b0;
        drive(4'b0110);
        tick();
        check("R6 mid-run reset", uop, pat(0));
        drive(4'b1111);
        tick();
        check("R6 reset held", uop, pat(0));
        rst_n = 1'b1;
        drive(4'b0000);
        tick();
        check("R6 restart from 0", uop, pat(1));

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule